// File: doc/BRIEF.md
# DMA Trigger and Completion Controller

This block keeps the start and finish bookkeeping for a bank of DMA channels. Each channel can be started in three ways: a peripheral event pulse, a software trigger write, or a chain trigger raised when another channel's transfer finishes. Peripheral events are latched per channel and only start the channel while that channel's event enable is set. A latched event that arrives while the enable is clear waits for the enable. Among all started channels, the lowest-numbered one is handed to the transfer engine through a valid/ready dispatch port.

The transfer engine reports each finished portion of work. A report carries a completion code, a flag that marks the last portion, and four enables: interrupt and chaining for the last portion, and interrupt and chaining for earlier portions. The completion code picks which pending bit to set, or which channel to start. The single interrupt output is high while any pending bit is set and its interrupt enable is also set. Chaining only raises the target channel's trigger and touches nothing else.

Software reaches the block through a one-cycle write strobe with a 3-bit register code and an N-bit mask. It can set and clear the event enables, set software triggers, set and clear the interrupt enables, clear pending bits and clear missed-event bits.

Top module: `dmaec_ctrl`

## Requirements
- R1: After synchronous reset the dispatch port is idle (`disp_valid_o`=0), `irq_o`=0, and every pending bit, missed bit, event enable and interrupt enable is 0.
- R2: A pulse on `periph_evt_i[c]` is latched for channel c. It starts c only while c's event enable is set, which is set by write code 0 and cleared by write code 1. An event latched while the enable is clear is dispatched once the enable is later set.
- R3: A write with code 2 starts every channel whose mask bit is 1.
- R4: When several channels are started at once, they are dispatched in ascending channel number, lowest first.
- R5: While `disp_valid_o` is 1 and `disp_ready_i` is 0, `disp_valid_o` and `disp_ch_o` hold. Loading a channel into the dispatch slot clears all of that channel's trigger sources, so each trigger yields exactly one dispatch.
- R6: A completion with `cmp_last_i`=1 and `cmp_irq_last_i`=1, or with `cmp_last_i`=0 and `cmp_irq_mid_i`=1, sets `pend_o[cmp_code_i]` on the next clock edge. The enable that belongs to the other kind of portion has no effect.
- R7: A completion with `cmp_last_i`=1 and `cmp_chain_last_i`=1, or with `cmp_last_i`=0 and `cmp_chain_mid_i`=1, starts channel `cmp_code_i`. Chaining sets no pending bit.
- R8: `irq_o` is 1 in exactly the cycles where some `pend_o` bit is set and its interrupt enable is set. The interrupt enables are set by write code 3 and cleared by write code 4. `irq_o` changes on the same edge as `pend_o`.
- R9: A write with code 5 clears every pending bit whose mask bit is 1 and leaves the others unchanged.
- R10: A peripheral event on a channel whose latched event bit is still set sets `miss_o` for that channel. A write with code 6 clears the masked missed bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_evt_i | input | NUM_CH | Peripheral event pulses, one per channel |
| wr_en_i | input | 1 | Control write strobe |
| wr_code_i | input | 3 | Write code: 0 enable set, 1 enable clear, 2 soft trigger, 3 irq enable set, 4 irq enable clear, 5 pending clear, 6 missed clear |
| wr_mask_i | input | NUM_CH | Channel mask for the write |
| cmp_valid_i | input | 1 | Completion report strobe |
| cmp_code_i | input | CH_W | Completion code (pending bit or chain target) |
| cmp_last_i | input | 1 | Report is for the last portion |
| cmp_irq_last_i | input | 1 | Interrupt enable for last portion |
| cmp_chain_last_i | input | 1 | Chaining enable for last portion |
| cmp_irq_mid_i | input | 1 | Interrupt enable for earlier portions |
| cmp_chain_mid_i | input | 1 | Chaining enable for earlier portions |
| disp_valid_o | output | 1 | Dispatch slot holds a channel |
| disp_ch_o | output | CH_W | Dispatched channel number |
| disp_ready_i | input | 1 | Engine accepts the dispatched channel |
| pend_o | output | NUM_CH | Interrupt pending bits |
| miss_o | output | NUM_CH | Missed-event bits |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench targets the crossing of portion kind and enable kind. A design that used the last-portion enables on earlier portions would set pending bits, or start chained channels, that must stay quiet. It starts several channels at once and expects ascending order; a wrong priority encoder would dispatch them in another order. It checks that a latched event waits for its enable and is dispatched exactly once. A design that failed to clear the trigger on dispatch would repeat the channel, and a design that dropped events while disabled would never dispatch it. It also checks that a chain completion leaves the pending bits untouched, that a masked pending clear spares the other bits, and that a second event on an unserviced channel is recorded as missed.

// File: rtl/dmaec_pkg.sv
package dmaec_pkg;
  typedef enum logic [2:0] {
    WR_EN_SET   = 3'd0,
    WR_EN_CLR   = 3'd1,
    WR_SOFT     = 3'd2,
    WR_IEN_SET  = 3'd3,
    WR_IEN_CLR  = 3'd4,
    WR_PEND_CLR = 3'd5,
    WR_MISS_CLR = 3'd6,
    WR_NONE     = 3'd7
  } wr_code_e;
endpackage

// File: rtl/dmaec_trig_bank.sv
module dmaec_trig_bank #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] periph_evt,
  input  logic [NUM_CH-1:0] en_set,
  input  logic [NUM_CH-1:0] en_clr,
  input  logic [NUM_CH-1:0] soft_set,
  input  logic [NUM_CH-1:0] chain_set,
  input  logic [NUM_CH-1:0] take,
  input  logic [NUM_CH-1:0] miss_clr,
  output logic [NUM_CH-1:0] trig,
  output logic [NUM_CH-1:0] miss
);
  logic [NUM_CH-1:0] en_q, evt_q, soft_q, chn_q, miss_q;

  // Sets win over the dispatch clear so a new trigger in the same cycle is kept.
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      evt_q  <= '0;
      soft_q <= '0;
      chn_q  <= '0;
      miss_q <= '0;
    end else begin
      en_q   <= (en_q & ~en_clr) | en_set;
      evt_q  <= (evt_q & ~take) | periph_evt;
      soft_q <= (soft_q & ~take) | soft_set;
      chn_q  <= (chn_q & ~take) | chain_set;
      miss_q <= (miss_q & ~miss_clr) | (periph_evt & evt_q & ~take);
    end
  end

  assign trig = (evt_q & en_q) | soft_q | chn_q;
  assign miss = miss_q;
endmodule

// File: rtl/dmaec_cmp_route.sv
module dmaec_cmp_route #(
  parameter int NUM_CH = 16,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_valid,
  input  logic [CH_W-1:0]   cmp_code,
  input  logic              cmp_last,
  input  logic              irq_last,
  input  logic              chain_last,
  input  logic              irq_mid,
  input  logic              chain_mid,
  input  logic [NUM_CH-1:0] ien_set,
  input  logic [NUM_CH-1:0] ien_clr,
  input  logic [NUM_CH-1:0] pend_clr,
  output logic [NUM_CH-1:0] chain_set,
  output logic [NUM_CH-1:0] pend,
  output logic              irq
);
  logic [NUM_CH-1:0] code_hot, pend_q, ien_q, pend_n, ien_n;
  logic              do_irq, do_chain, irq_q;

  always_comb begin
    code_hot = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (cmp_code == CH_W'(i)) code_hot[i] = 1'b1;
    end
  end

  assign do_irq    = cmp_valid && (cmp_last ? irq_last : irq_mid);
  assign do_chain  = cmp_valid && (cmp_last ? chain_last : chain_mid);
  assign chain_set = do_chain ? code_hot : '0;

  assign pend_n = (pend_q & ~pend_clr) | (do_irq ? code_hot : '0);
  assign ien_n  = (ien_q & ~ien_clr) | ien_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      ien_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      ien_q  <= ien_n;
      irq_q  <= |(pend_n & ien_n);
    end
  end

  assign pend = pend_q;
  assign irq  = irq_q;
endmodule

// File: rtl/dmaec_pick.sv
module dmaec_pick #(
  parameter int NUM_CH = 16,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] trig,
  input  logic              ready,
  output logic [NUM_CH-1:0] take,
  output logic              valid,
  output logic [CH_W-1:0]   ch
);
  logic [NUM_CH-1:0] low_hot;
  logic [CH_W-1:0]   low_idx;
  logic              found, slot_free, valid_q;
  logic [CH_W-1:0]   ch_q;

  always_comb begin
    low_hot = '0;
    low_idx = '0;
    found   = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (trig[i] && !found) begin
        low_hot[i] = 1'b1;
        low_idx    = CH_W'(i);
        found      = 1'b1;
      end
    end
  end

  assign slot_free = !valid_q || ready;
  assign take      = (slot_free && found) ? low_hot : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      ch_q    <= '0;
    end else if (slot_free) begin
      valid_q <= found;
      if (found) ch_q <= low_idx;
    end
  end

  assign valid = valid_q;
  assign ch    = ch_q;
endmodule

// File: rtl/dmaec_ctrl.sv
module dmaec_ctrl #(
  parameter int NUM_CH = 16,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] periph_evt_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_code_i,
  input  logic [NUM_CH-1:0] wr_mask_i,
  input  logic              cmp_valid_i,
  input  logic [CH_W-1:0]   cmp_code_i,
  input  logic              cmp_last_i,
  input  logic              cmp_irq_last_i,
  input  logic              cmp_chain_last_i,
  input  logic              cmp_irq_mid_i,
  input  logic              cmp_chain_mid_i,
  output logic              disp_valid_o,
  output logic [CH_W-1:0]   disp_ch_o,
  input  logic              disp_ready_i,
  output logic [NUM_CH-1:0] pend_o,
  output logic [NUM_CH-1:0] miss_o,
  output logic              irq_o
);
  import dmaec_pkg::*;

  wr_code_e          code;
  logic [NUM_CH-1:0] en_set, en_clr, soft_set, ien_set, ien_clr, pend_clr, miss_clr;
  logic [NUM_CH-1:0] chain_w, trig_w, take_w;

  assign code = wr_code_e'(wr_code_i);

  always_comb begin
    en_set   = '0;
    en_clr   = '0;
    soft_set = '0;
    ien_set  = '0;
    ien_clr  = '0;
    pend_clr = '0;
    miss_clr = '0;
    if (wr_en_i) begin
      case (code)
        WR_EN_SET:   en_set   = wr_mask_i;
        WR_EN_CLR:   en_clr   = wr_mask_i;
        WR_SOFT:     soft_set = wr_mask_i;
        WR_IEN_SET:  ien_set  = wr_mask_i;
        WR_IEN_CLR:  ien_clr  = wr_mask_i;
        WR_PEND_CLR: pend_clr = wr_mask_i;
        WR_MISS_CLR: miss_clr = wr_mask_i;
        default:     ;
      endcase
    end
  end

  dmaec_trig_bank #(.NUM_CH(NUM_CH)) u_trig (
    .clk       (clk),
    .rst       (rst),
    .periph_evt(periph_evt_i),
    .en_set    (en_set),
    .en_clr    (en_clr),
    .soft_set  (soft_set),
    .chain_set (chain_w),
    .take      (take_w),
    .miss_clr  (miss_clr),
    .trig      (trig_w),
    .miss      (miss_o)
  );

  dmaec_cmp_route #(.NUM_CH(NUM_CH)) u_route (
    .clk       (clk),
    .rst       (rst),
    .cmp_valid (cmp_valid_i),
    .cmp_code  (cmp_code_i),
    .cmp_last  (cmp_last_i),
    .irq_last  (cmp_irq_last_i),
    .chain_last(cmp_chain_last_i),
    .irq_mid   (cmp_irq_mid_i),
    .chain_mid (cmp_chain_mid_i),
    .ien_set   (ien_set),
    .ien_clr   (ien_clr),
    .pend_clr  (pend_clr),
    .chain_set (chain_w),
    .pend      (pend_o),
    .irq       (irq_o)
  );

  dmaec_pick #(.NUM_CH(NUM_CH)) u_pick (
    .clk  (clk),
    .rst  (rst),
    .trig (trig_w),
    .ready(disp_ready_i),
    .take (take_w),
    .valid(disp_valid_o),
    .ch   (disp_ch_o)
  );
endmodule

// File: rtl/dmaec_ctrl_chk.sv
module dmaec_ctrl_chk #(
  parameter int NUM_CH = 16,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] periph_evt_i,
  input logic              cmp_valid_i,
  input logic [CH_W-1:0]   cmp_code_i,
  input logic              cmp_last_i,
  input logic              cmp_irq_last_i,
  input logic              disp_valid_o,
  input logic [CH_W-1:0]   disp_ch_o,
  input logic              disp_ready_i,
  input logic [NUM_CH-1:0] pend_o,
  input logic [NUM_CH-1:0] miss_o,
  input logic              irq_o,
  input logic [NUM_CH-1:0] take_w
);
  // R5: dispatch slot holds while the engine stalls
  p_disp_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (disp_valid_o && !disp_ready_i) |=> (disp_valid_o && $stable(disp_ch_o)));

  // R4: at most one channel is taken per cycle
  p_take_single_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(take_w));

  // R6: last-portion completion with interrupt enable raises its pending bit
  p_pend_set_r6: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid_i && cmp_last_i && cmp_irq_last_i) |=> pend_o[$past(cmp_code_i)]);

  // R8: the interrupt never fires without a pending bit
  p_irq_needs_pend_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (pend_o != '0));

  // R10: a new missed bit always follows a peripheral event
  p_miss_cause_r10: assert property (@(posedge clk) disable iff (rst)
    ((miss_o & ~$past(miss_o)) != '0) |-> ($past(periph_evt_i) != '0));
endmodule

bind dmaec_ctrl dmaec_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .periph_evt_i  (periph_evt_i),
  .cmp_valid_i   (cmp_valid_i),
  .cmp_code_i    (cmp_code_i),
  .cmp_last_i    (cmp_last_i),
  .cmp_irq_last_i(cmp_irq_last_i),
  .disp_valid_o  (disp_valid_o),
  .disp_ch_o     (disp_ch_o),
  .disp_ready_i  (disp_ready_i),
  .pend_o        (pend_o),
  .miss_o        (miss_o),
  .irq_o         (irq_o),
  .take_w        (take_w)
);

// File: tb/dmaec_ctrl_bench.sv
module dmaec_ctrl_bench;
  localparam int NCH = 16;
  localparam int CW  = 4;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst;
  logic [NCH-1:0] periph_evt;
  logic wr_en;
  logic [2:0] wr_code;
  logic [NCH-1:0] wr_mask;
  logic cmp_valid, cmp_last, c_il, c_cl, c_im, c_cm;
  logic [CW-1:0] cmp_code;
  logic disp_valid, disp_ready, irq;
  logic [CW-1:0] disp_ch;
  logic [NCH-1:0] pend, miss;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmaec_ctrl #(.NUM_CH(NCH)) u_dmaec_ctrl (
    .clk(clk), .rst(rst), .periph_evt_i(periph_evt),
    .wr_en_i(wr_en), .wr_code_i(wr_code), .wr_mask_i(wr_mask),
    .cmp_valid_i(cmp_valid), .cmp_code_i(cmp_code), .cmp_last_i(cmp_last),
    .cmp_irq_last_i(c_il), .cmp_chain_last_i(c_cl),
    .cmp_irq_mid_i(c_im), .cmp_chain_mid_i(c_cm),
    .disp_valid_o(disp_valid), .disp_ch_o(disp_ch), .disp_ready_i(disp_ready),
    .pend_o(pend), .miss_o(miss), .irq_o(irq)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [2:0] c, input logic [NCH-1:0] m);
    @(negedge clk);
    wr_en = 1'b1; wr_code = c; wr_mask = m;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_evt(input logic [NCH-1:0] m);
    @(negedge clk);
    periph_evt = m;
    @(negedge clk);
    periph_evt = '0;
  endtask

  task automatic complete(input int code, input bit last, input bit il, input bit cl,
                          input bit im, input bit cm);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_code = CW'(code); cmp_last = last;
    c_il = il; c_cl = cl; c_im = im; c_cm = cm;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  task automatic expect_dispatch(input int exp, input string tag);
    int waited = 0;
    while (!disp_valid && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    check(disp_valid && disp_ch == CW'(exp), tag, disp_valid ? longint'(disp_ch) : -1, exp);
    disp_ready = 1'b1;
    @(negedge clk);
    disp_ready = 1'b0;
  endtask

  task automatic expect_idle(input int n, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (disp_valid) seen = 1'b1;
    end
    check(!seen, tag, seen, 0);
  endtask

  task automatic t_reset;
    check(!disp_valid && !irq && pend == '0 && miss == '0, "R1 reset state",
          {disp_valid, irq, pend, miss}, 0);
    expect_idle(4, "R1 no dispatch after reset");
  endtask

  task automatic t_periph;
    pulse_evt(NCH'(1) << 6);
    expect_idle(8, "R2 disabled event not dispatched");
    check(miss == '0, "R10 single event not missed", miss, 0);
    write_reg(3'd0, NCH'(1) << 6);
    expect_dispatch(6, "R2 latched event dispatched after enable");
    expect_idle(6, "R5 one dispatch per event");
    pulse_evt(NCH'(1) << 6);
    expect_dispatch(6, "R2 enabled event dispatched");
    write_reg(3'd1, NCH'(1) << 6);
  endtask

  task automatic t_soft_priority;
    write_reg(3'd2, (NCH'(1) << 9) | (NCH'(1) << 2) | (NCH'(1) << 5));
    repeat (3) @(negedge clk);
    check(disp_valid && disp_ch == 2, "R5 slot holds while stalled", disp_ch, 2);
    expect_dispatch(2, "R4 lowest first");
    expect_dispatch(5, "R4 second lowest");
    expect_dispatch(9, "R3 soft trigger last channel");
    expect_idle(5, "R5 triggers cleared after dispatch");
  endtask

  task automatic t_completion_irq;
    complete(3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check(pend == (NCH'(1) << 3), "R6 last portion sets pending", pend, NCH'(1) << 3);
    check(!irq, "R8 no irq while enable clear", irq, 0);
    write_reg(3'd3, NCH'(1) << 3);
    check(irq, "R8 irq after enable", irq, 1);
    complete(4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check(pend == ((NCH'(1) << 3) | (NCH'(1) << 4)), "R6 mid portion sets pending",
          pend, (NCH'(1) << 3) | (NCH'(1) << 4));
    write_reg(3'd5, NCH'(1) << 3);
    check(pend == (NCH'(1) << 4), "R9 masked pending clear", pend, NCH'(1) << 4);
    check(!irq, "R8 irq drops when enabled bit cleared", irq, 0);
    complete(8, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    complete(8, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    check(pend == (NCH'(1) << 4), "R6 wrong-kind enables ignored", pend, NCH'(1) << 4);
    write_reg(3'd5, '1);
    check(pend == '0, "R9 clear all", pend, 0);
    write_reg(3'd4, '1);
  endtask

  task automatic t_chain;
    complete(7, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    expect_dispatch(7, "R7 last-portion chain starts target");
    check(pend == '0, "R7 chain sets no pending", pend, 0);
    complete(11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    expect_dispatch(11, "R7 mid-portion chain starts target");
    complete(12, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    expect_idle(6, "R7 mid chain enable ignored on last portion");
    complete(12, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    expect_idle(6, "R7 last chain enable ignored on mid portion");
  endtask

  task automatic t_missed;
    pulse_evt(NCH'(1) << 10);
    pulse_evt(NCH'(1) << 10);
    check(miss == (NCH'(1) << 10), "R10 second event recorded as missed", miss, NCH'(1) << 10);
    write_reg(3'd6, NCH'(1) << 10);
    check(miss == '0, "R10 missed clear", miss, 0);
    write_reg(3'd0, NCH'(1) << 10);
    expect_dispatch(10, "R2 missed channel still dispatched once");
    expect_idle(5, "R5 no repeat after missed event");
    write_reg(3'd1, NCH'(1) << 10);
  endtask

  initial begin
    rst = 1'b1; periph_evt = '0; wr_en = 1'b0; wr_code = 3'd7; wr_mask = '0;
    cmp_valid = 1'b0; cmp_code = '0; cmp_last = 1'b0;
    c_il = 1'b0; c_cl = 1'b0; c_im = 1'b0; c_cm = 1'b0; disp_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_periph();
    t_soft_priority();
    t_completion_irq();
    t_chain();
    t_missed();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule